// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits behind the write port of an emulated parallel NOR flash and turns the stream of bus write cycles into decoded flash commands. Each write carries a word offset and a data byte. The sequencer follows the multi-cycle protocol: an unlock pair, then a command byte. For erase, a further unlock pair and then a confirm byte. It emits a one-cycle command strobe with the command kind, offset and data. It also reports a one-cycle error flag whenever it rejects a write. The two unlock offsets are configuration inputs, not constants, so the same block serves devices wired with different address strapping.

The block also selects what a read returns. In query mode a read returns an entry of a small parameter table; in identifier mode it returns one of four configured identifier words. An unlock-bypass mode lets software send command bytes without repeating the unlock pair. The storage array, program and erase timing and the bus electricals are handled elsewhere.

Top module: `nor_cmd_seq`

## Requirements
- R1: Reset is synchronous and active high. After reset the block is in the idle state with `rd_mode`=0 (array), `bypass_on`=0, `cmd_valid`=0, `cmd_kind`=0, `seq_err`=0 and `rd_data`=0.
- R2: In the idle state, outside bypass, a write of 0xAA at offset `cfg_unlock_a` advances the sequence. Any other write except 0xF0 and 0x98 is rejected.
- R3: The write after a valid first unlock must be 0x55 at offset `cfg_unlock_b`. Anything else except 0xF0 is rejected.
- R4: The write after the unlock pair is the command byte and must target `cfg_unlock_a`. Outside bypass, any other offset is rejected whatever the byte.
- R5: The unlock offsets are sampled live from `cfg_unlock_a`/`cfg_unlock_b`, so changing them at run time changes which offsets unlock. The usual values are 0x555 and 0x2AA.
- R6: Command byte 0xA0 arms programming. The next write (other than 0xF0), at any offset, raises `cmd_valid` with `cmd_kind`=1, and `cmd_off`/`cmd_data` equal that write's offset and data.
- R7: Command byte 0x80 arms erase and needs a second unlock pair (0xAA at A, 0x55 at B). The following byte then decides the action. 0x10 at `cfg_unlock_a` gives chip erase (`cmd_kind`=3). 0x10 at any other offset is rejected. 0x30 at any offset gives sector erase (`cmd_kind`=2) with that offset on `cmd_off`.
- R8: Byte 0x98, written in the idle state at any offset or used as a command byte, gives `cmd_kind`=4 and `rd_mode`=1. In query mode the read at offset i returns these entries, zero-extended: 0x51, 0x52, 0x59 at i=0..2; 0x02 at 3; log2 of device bytes at 5; sector count minus one, low byte then high byte, at 6..7; sector bytes/256, low byte then high byte, at 8..9. Every other i below 0x52, and every i of 0x52 or more, returns 0. In array mode a read returns 0.
- R9: Command byte 0x90 outside bypass gives `cmd_kind`=5 and `rd_mode`=2. A read then returns identifier word `rd_off[1:0]`, where word k is `cfg_ident[16k+15:16k]`.
- R10: A write of 0xF0 in any state and at any offset gives `cmd_kind`=6, sets `rd_mode` to 0 and returns to idle. The bypass setting is left unchanged.
- R11: Command byte 0x20 outside bypass sets `bypass_on`. While bypass is on, a write in the idle state (other than 0xF0/0x98) is the command byte at any offset. In bypass, 0x90 then 0x00 clears bypass, 0x90 followed by any other byte is rejected with bypass kept, and 0x20 is rejected.
- R12: A rejected write raises `seq_err` for exactly one cycle with `cmd_valid` low and returns the sequencer to idle. Mode and bypass are unchanged.
- R13: The effects of a write appear on the outputs in the cycle after it, and `cmd_valid`/`seq_err` are low after any cycle without a write. A read uses the mode in force before any write in the same cycle, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write cycle present |
| wr_off | input | OFF_W | Word offset of the write |
| wr_data | input | 8 | Data byte of the write |
| cfg_unlock_a | input | OFF_W | First unlock offset, also the command offset |
| cfg_unlock_b | input | OFF_W | Second unlock offset |
| cfg_ident | input | ID_N*ID_W | Identifier words, word k at bits [ID_W*k +: ID_W] |
| rd_off | input | OFF_W | Read offset |
| cmd_valid | output | 1 | One-cycle decoded command strobe |
| cmd_kind | output | 3 | 0 none, 1 program, 2 sector erase, 3 chip erase, 4 query, 5 identifier, 6 reset |
| cmd_off | output | OFF_W | Offset of the write that completed the command |
| cmd_data | output | 8 | Data of the write that completed the command |
| seq_err | output | 1 | One-cycle flag: write rejected |
| rd_mode | output | 2 | 0 array, 1 query, 2 identifier |
| bypass_on | output | 1 | Unlock-bypass mode active |
| rd_data | output | ID_W | Read data for the current mode |

## Verification
A read and a mode-changing write can land in the same cycle. The bench sweeps `rd_off` on every clock across the whole table and past its end, so the reads run while the 0x98, 0x90 and 0xF0 writes take effect. The reference model computes each read from the mode held before that cycle's write, and the design is compared with it on every clock. A second coincidence is the reset byte arriving in the cycle that would complete a program or an erase. The model expects the reset strobe and no program strobe, and the error flag must stay low.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_UNLK1 = 3'd1,
    S_CMD   = 3'd2,
    S_PROG  = 3'd3,
    S_ERS1  = 3'd4,
    S_ERS2  = 3'd5,
    S_ERS3  = 3'd6,
    S_BYX   = 3'd7
  } seq_state_t;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_PROG  = 3'd1,
    K_SECT  = 3'd2,
    K_CHIP  = 3'd3,
    K_QUERY = 3'd4,
    K_IDENT = 3'd5,
    K_RESET = 3'd6
  } cmd_kind_t;

  typedef enum logic [1:0] {
    M_ARRAY = 2'd0,
    M_QUERY = 2'd1,
    M_IDENT = 2'd2
  } rd_mode_t;

  localparam logic [7:0] B_KEY0    = 8'hAA;
  localparam logic [7:0] B_KEY1    = 8'h55;
  localparam logic [7:0] B_RESET   = 8'hF0;
  localparam logic [7:0] B_QUERY   = 8'h98;
  localparam logic [7:0] B_IDENT   = 8'h90;
  localparam logic [7:0] B_PROG    = 8'hA0;
  localparam logic [7:0] B_ERASE   = 8'h80;
  localparam logic [7:0] B_CHIP    = 8'h10;
  localparam logic [7:0] B_SECT    = 8'h30;
  localparam logic [7:0] B_BYP_ON  = 8'h20;
  localparam logic [7:0] B_BYP_OFF = 8'h00;

endpackage

// File: rtl/nor_query_rom.sv
module nor_query_rom #(
  parameter int OFF_W         = 12,
  parameter int QT_DEPTH      = 82,
  parameter int DEV_SIZE_LOG2 = 22,
  parameter int SECT_COUNT    = 64,
  parameter int SECT_BYTES    = 65536
) (
  input  logic             clk,
  input  logic [OFF_W-1:0] addr,
  output logic [7:0]       q
);
  localparam int QA_W = $clog2(QT_DEPTH);
  localparam logic [OFF_W-1:0] QT_LIM = OFF_W'(QT_DEPTH);
  localparam int SC_M1 = SECT_COUNT - 1;
  localparam int SB_PG = SECT_BYTES / 256;

  function automatic logic [7:0] qt_entry(input int i);
    case (i)
      0: return 8'h51;
      1: return 8'h52;
      2: return 8'h59;
      3: return 8'h02;
      5: return 8'(DEV_SIZE_LOG2);
      6: return 8'(SC_M1 % 256);
      7: return 8'(SC_M1 / 256);
      8: return 8'(SB_PG % 256);
      9: return 8'(SB_PG / 256);
      default: return 8'h00;
    endcase
  endfunction

  logic [7:0] mem [QT_DEPTH];

  initial begin
    for (int i = 0; i < QT_DEPTH; i++) mem[i] = qt_entry(i);
  end

  always_ff @(posedge clk) begin
    if (addr < QT_LIM) q <= mem[addr[QA_W-1:0]];
    else               q <= 8'h00;
  end
endmodule

// File: rtl/nor_read_path.sv
module nor_read_path
  import nor_seq_pkg::*;
#(
  parameter int OFF_W         = 12,
  parameter int ID_W          = 16,
  parameter int ID_N          = 4,
  parameter int QT_DEPTH      = 82,
  parameter int DEV_SIZE_LOG2 = 22,
  parameter int SECT_COUNT    = 64,
  parameter int SECT_BYTES    = 65536
) (
  input  logic                 clk,
  input  logic                 rst,
  input  rd_mode_t             mode,
  input  logic [OFF_W-1:0]     rd_off,
  input  logic [ID_N*ID_W-1:0] ident,
  output logic [ID_W-1:0]      rd_data
);
  localparam int IDSEL_W = $clog2(ID_N);

  logic [ID_W-1:0] words [ID_N];
  logic [ID_W-1:0] id_q;
  logic [7:0]      qt_q;
  rd_mode_t        sel_q;

  for (genvar g = 0; g < ID_N; g++) begin : g_word
    assign words[g] = ident[g*ID_W +: ID_W];
  end

  nor_query_rom #(
    .OFF_W(OFF_W), .QT_DEPTH(QT_DEPTH), .DEV_SIZE_LOG2(DEV_SIZE_LOG2),
    .SECT_COUNT(SECT_COUNT), .SECT_BYTES(SECT_BYTES)
  ) u_rom (
    .clk (clk),
    .addr(rd_off),
    .q   (qt_q)
  );

  always_ff @(posedge clk) begin
    id_q <= words[rd_off[IDSEL_W-1:0]];
    if (rst) sel_q <= M_ARRAY;
    else     sel_q <= mode;
  end

  always_comb begin
    case (sel_q)
      M_QUERY: rd_data = ID_W'(qt_q);
      M_IDENT: rd_data = id_q;
      default: rd_data = '0;
    endcase
  end

  // R8: array mode reads back zero one cycle later
  a_r8_array_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (mode == M_ARRAY) |=> (rd_data == '0));
endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
  import nor_seq_pkg::*;
#(
  parameter int OFF_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [7:0]       wr_data,
  input  logic [OFF_W-1:0] unlock_a,
  input  logic [OFF_W-1:0] unlock_b,
  output logic             cmd_valid,
  output cmd_kind_t        cmd_kind,
  output logic [OFF_W-1:0] cmd_off,
  output logic [7:0]       cmd_data,
  output logic             seq_err,
  output rd_mode_t         mode,
  output logic             bypass_on
);
  seq_state_t state, st_n;
  logic       byp_n, val_n, err_n, cmd_cycle;
  cmd_kind_t  kind_n;
  rd_mode_t   mode_n;
  logic       at_a, at_b;

  assign at_a = (wr_off == unlock_a);
  assign at_b = (wr_off == unlock_b);
  assign cmd_cycle = ((state == S_IDLE) && bypass_on) ||
                     ((state == S_CMD) && (bypass_on || at_a));

  always_comb begin
    st_n   = state;
    byp_n  = bypass_on;
    mode_n = mode;
    val_n  = 1'b0;
    err_n  = 1'b0;
    kind_n = K_NONE;
    if (wr_en) begin
      if (wr_data == B_RESET) begin
        val_n = 1'b1; kind_n = K_RESET; mode_n = M_ARRAY; st_n = S_IDLE;
      end else if ((state == S_IDLE) && (wr_data == B_QUERY)) begin
        val_n = 1'b1; kind_n = K_QUERY; mode_n = M_QUERY;
      end else if (cmd_cycle) begin
        st_n = S_IDLE;
        case (wr_data)
          B_PROG:  st_n = S_PROG;
          B_ERASE: st_n = S_ERS1;
          B_QUERY: begin val_n = 1'b1; kind_n = K_QUERY; mode_n = M_QUERY; end
          B_IDENT: begin
            if (bypass_on) st_n = S_BYX;
            else begin val_n = 1'b1; kind_n = K_IDENT; mode_n = M_IDENT; end
          end
          B_BYP_ON: begin
            if (!bypass_on) byp_n = 1'b1;
            else            err_n = 1'b1;
          end
          default: err_n = 1'b1;
        endcase
      end else begin
        st_n = S_IDLE;
        case (state)
          S_IDLE:  if (at_a && wr_data == B_KEY0) st_n = S_UNLK1; else err_n = 1'b1;
          S_UNLK1: if (at_b && wr_data == B_KEY1) st_n = S_CMD;   else err_n = 1'b1;
          S_PROG:  begin val_n = 1'b1; kind_n = K_PROG; end
          S_ERS1:  if (at_a && wr_data == B_KEY0) st_n = S_ERS2;  else err_n = 1'b1;
          S_ERS2:  if (at_b && wr_data == B_KEY1) st_n = S_ERS3;  else err_n = 1'b1;
          S_ERS3: begin
            if (wr_data == B_SECT)               begin val_n = 1'b1; kind_n = K_SECT; end
            else if (wr_data == B_CHIP && at_a)  begin val_n = 1'b1; kind_n = K_CHIP; end
            else                                 err_n = 1'b1;
          end
          S_BYX: begin
            if (wr_data == B_BYP_OFF) byp_n = 1'b0;
            else                      err_n = 1'b1;
          end
          default: err_n = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      bypass_on <= 1'b0;
      mode      <= M_ARRAY;
      cmd_valid <= 1'b0;
      cmd_kind  <= K_NONE;
      seq_err   <= 1'b0;
      cmd_off   <= '0;
      cmd_data  <= '0;
    end else begin
      state     <= st_n;
      bypass_on <= byp_n;
      mode      <= mode_n;
      cmd_valid <= val_n;
      cmd_kind  <= kind_n;
      seq_err   <= err_n;
      if (wr_en) begin
        cmd_off  <= wr_off;
        cmd_data <= wr_data;
      end
    end
  end

  // R13: no write, no strobe and no error in the next cycle
  a_r13_quiet_without_write: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !(cmd_valid || seq_err));

  // R10: the reset byte always wins
  a_r10_reset_byte_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data == B_RESET) |=> (cmd_valid && cmd_kind == K_RESET && mode == M_ARRAY));

  // R4: wrong command offset outside bypass is rejected
  a_r4_cmd_offset: assert property (@(posedge clk) disable iff (rst)
    (wr_en && state == S_CMD && !bypass_on && !at_a && wr_data != B_RESET) |=> seq_err);

  // R6: program strobe carries the offset and data of its write
  a_r6_prog_payload: assert property (@(posedge clk) disable iff (rst)
    (wr_en && state == S_PROG && wr_data != B_RESET) |=>
      (cmd_valid && cmd_kind == K_PROG && cmd_off == $past(wr_off) && cmd_data == $past(wr_data)));

  // R11: bypass is left only through the exit pair
  a_r11_bypass_exit: assert property (@(posedge clk) disable iff (rst)
    $fell(bypass_on) |-> ($past(state) == S_BYX && $past(wr_data) == B_BYP_OFF));

  // R12: an error is never paired with a strobe
  a_r12_err_alone: assert property (@(posedge clk) disable iff (rst)
    seq_err |-> !cmd_valid);
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int OFF_W         = 12,
  parameter int ID_W          = 16,
  parameter int ID_N          = 4,
  parameter int QT_DEPTH      = 82,
  parameter int DEV_SIZE_LOG2 = 22,
  parameter int SECT_COUNT    = 64,
  parameter int SECT_BYTES    = 65536
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [OFF_W-1:0]     wr_off,
  input  logic [7:0]           wr_data,
  input  logic [OFF_W-1:0]     cfg_unlock_a,
  input  logic [OFF_W-1:0]     cfg_unlock_b,
  input  logic [ID_N*ID_W-1:0] cfg_ident,
  input  logic [OFF_W-1:0]     rd_off,
  output logic                 cmd_valid,
  output logic [2:0]           cmd_kind,
  output logic [OFF_W-1:0]     cmd_off,
  output logic [7:0]           cmd_data,
  output logic                 seq_err,
  output logic [1:0]           rd_mode,
  output logic                 bypass_on,
  output logic [ID_W-1:0]      rd_data
);
  cmd_kind_t kind_w;
  rd_mode_t  mode_w;

  assign cmd_kind = kind_w;
  assign rd_mode  = mode_w;

  nor_seq_fsm #(.OFF_W(OFF_W)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_off   (wr_off),
    .wr_data  (wr_data),
    .unlock_a (cfg_unlock_a),
    .unlock_b (cfg_unlock_b),
    .cmd_valid(cmd_valid),
    .cmd_kind (kind_w),
    .cmd_off  (cmd_off),
    .cmd_data (cmd_data),
    .seq_err  (seq_err),
    .mode     (mode_w),
    .bypass_on(bypass_on)
  );

  nor_read_path #(
    .OFF_W(OFF_W), .ID_W(ID_W), .ID_N(ID_N), .QT_DEPTH(QT_DEPTH),
    .DEV_SIZE_LOG2(DEV_SIZE_LOG2), .SECT_COUNT(SECT_COUNT), .SECT_BYTES(SECT_BYTES)
  ) u_rd (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode_w),
    .rd_off (rd_off),
    .ident  (cfg_ident),
    .rd_data(rd_data)
  );
endmodule

// File: tb/tb_nor_cmd_seq.sv
`timescale 1ns/1ps
module tb_nor_cmd_seq;
  localparam int OFF_W = 12;
  localparam int ID_W  = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [OFF_W-1:0] wr_off = '0;
  logic [7:0]       wr_data = '0;
  logic [OFF_W-1:0] cfg_unlock_a = 12'h555;
  logic [OFF_W-1:0] cfg_unlock_b = 12'h2AA;
  logic [63:0]      cfg_ident = 64'h0000_0000_22DA_0001;
  logic [OFF_W-1:0] rd_off = '0;
  logic             cmd_valid, seq_err, bypass_on;
  logic [2:0]       cmd_kind;
  logic [OFF_W-1:0] cmd_off;
  logic [7:0]       cmd_data;
  logic [1:0]       rd_mode;
  logic [ID_W-1:0]  rd_data;

  nor_cmd_seq dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .cfg_unlock_a(cfg_unlock_a), .cfg_unlock_b(cfg_unlock_b), .cfg_ident(cfg_ident),
    .rd_off(rd_off), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_off(cmd_off),
    .cmd_data(cmd_data), .seq_err(seq_err), .rd_mode(rd_mode), .bypass_on(bypass_on),
    .rd_data(rd_data)
  );

  int n_chk = 0, n_fail = 0, rdo = 0;
  string req = "R1";
  bit done = 1'b0;

  // reference state: 0 idle,1 after key0,2 command,3 program,4..6 erase steps,7 bypass exit
  int m_st = 0, m_mode = 0;
  bit m_byp = 1'b0;
  int e_val = 0, e_kind = 0, e_off = 0, e_data = 0, e_err = 0, e_rd = 0;

  function automatic int qexp(int i);
    if (i == 0) return 'h51;
    if (i == 1) return 'h52;
    if (i == 2) return 'h59;
    if (i == 3) return 'h02;
    if (i == 5) return 22;
    if (i == 6) return 63;
    if (i == 8) return 0;
    if (i == 9) return 1;
    return 0;
  endfunction

  task automatic model(bit we, int off, int d, int ro);
    int ua, ub, nx;
    bit cmdc;
    logic [63:0] sh;
    ua = int'(cfg_unlock_a);
    ub = int'(cfg_unlock_b);
    if (m_mode == 1) e_rd = (ro < 82) ? qexp(ro) : 0;
    else if (m_mode == 2) begin sh = cfg_ident >> (16 * (ro % 4)); e_rd = int'(sh[15:0]); end
    else e_rd = 0;
    e_val = 0; e_kind = 0; e_err = 0;
    if (!we) return;
    e_off = off; e_data = d;
    if (d == 'hF0) begin e_val = 1; e_kind = 6; m_mode = 0; m_st = 0; return; end
    if (m_st == 0 && d == 'h98) begin e_val = 1; e_kind = 4; m_mode = 1; return; end
    cmdc = (m_st == 0 && m_byp) || (m_st == 2 && (m_byp || off == ua));
    nx = 0;
    if (cmdc) begin
      if (d == 'hA0) nx = 3;
      else if (d == 'h80) nx = 4;
      else if (d == 'h98) begin e_val = 1; e_kind = 4; m_mode = 1; end
      else if (d == 'h90 && m_byp) nx = 7;
      else if (d == 'h90) begin e_val = 1; e_kind = 5; m_mode = 2; end
      else if (d == 'h20 && !m_byp) m_byp = 1'b1;
      else e_err = 1;
    end else if (m_st == 0) begin
      if (off == ua && d == 'hAA) nx = 1; else e_err = 1;
    end else if (m_st == 1) begin
      if (off == ub && d == 'h55) nx = 2; else e_err = 1;
    end else if (m_st == 3) begin
      e_val = 1; e_kind = 1;
    end else if (m_st == 4) begin
      if (off == ua && d == 'hAA) nx = 5; else e_err = 1;
    end else if (m_st == 5) begin
      if (off == ub && d == 'h55) nx = 6; else e_err = 1;
    end else if (m_st == 6) begin
      if (d == 'h30) begin e_val = 1; e_kind = 2; end
      else if (d == 'h10 && off == ua) begin e_val = 1; e_kind = 3; end
      else e_err = 1;
    end else if (m_st == 7) begin
      if (d == 'h00) m_byp = 1'b0; else e_err = 1;
    end else e_err = 1;
    m_st = nx;
  endtask

  task automatic check();
    bit bad;
    n_chk++;
    bad = (int'(cmd_valid) != e_val) || (int'(cmd_kind) != e_kind) || (int'(seq_err) != e_err) ||
          (int'(rd_mode) != m_mode) || (bypass_on != m_byp) || (int'(rd_data) != e_rd) ||
          (e_val == 1 && (int'(cmd_off) != e_off || int'(cmd_data) != e_data));
    if (bad) begin
      n_fail++;
      $display("FAIL %s t=%0t actual v=%0d k=%0d off=%h d=%h err=%0d mode=%0d byp=%0d rd=%h expected v=%0d k=%0d off=%h d=%h err=%0d mode=%0d byp=%0d rd=%h",
        req, $time, cmd_valid, cmd_kind, cmd_off, cmd_data, seq_err, rd_mode, bypass_on, rd_data,
        e_val, e_kind, e_off, e_data, e_err, m_mode, m_byp, e_rd);
    end
  endtask

  task automatic cyc(bit we, int off, int d);
    wr_en = we; wr_off = OFF_W'(off); wr_data = 8'(d);
    rd_off = OFF_W'(rdo % 88);
    model(we, off, d, rdo % 88);
    rdo++;
    @(negedge clk);
    check();
  endtask

  task automatic w(int off, int d); cyc(1'b1, off, d); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) cyc(1'b0, 0, 0); endtask
  task automatic unlock(); w(int'(cfg_unlock_a), 'hAA); w(int'(cfg_unlock_b), 'h55); endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung run, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    req = "R1"; idle(2);                                   // R1 reset state
    req = "R2"; w('h554, 'hAA); w('h555, 'h55); w('h555, 'hAB); idle(1);
    req = "R3"; w('h555, 'hAA); w('h2AB, 'h55); w('h555, 'hAA); w('h2AA, 'h54);
    req = "R4"; unlock(); w('h554, 'hA0); w('h123, 'h77);
    req = "R6"; unlock(); w('h555, 'hA0); w('h3C1, 'h5A); idle(1);
    req = "R5"; cfg_unlock_a = 12'hAAA; cfg_unlock_b = 12'h555;
    w('h555, 'hAA); unlock(); w('hAAA, 'hA0); w('h007, 'hC3);
    cfg_unlock_a = 12'h555; cfg_unlock_b = 12'h2AA;
    req = "R7"; unlock(); w('h555, 'h80); unlock(); w('h555, 'h10);
    unlock(); w('h555, 'h80); unlock(); w('h100, 'h30);
    unlock(); w('h555, 'h80); unlock(); w('h554, 'h10);
    unlock(); w('h555, 'h80); w('h556, 'hAA);
    req = "R8"; w('h000, 'h98); idle(90); w('h0, 'hF0);
    unlock(); w('h555, 'h98); idle(12);
    req = "R13"; w('h9, 'hF0); w('h9, 'hF0); w('h1, 'h98); w('h2, 'hF0); idle(1);
    req = "R9"; cfg_ident = 64'h1234_ABCD_22DA_0001;
    unlock(); w('h555, 'h90); idle(8); w('h4, 'hF0);
    req = "R10"; w('h555, 'hAA); w('h9, 'hF0); unlock(); w('h555, 'hA0); w('h10, 'hF0); w('h10, 'h11);
    req = "R11"; unlock(); w('h555, 'h20); w('h77, 'hA0); w('h78, 'h9C);
    w('h1, 'h20); w('h5, 'h90); w('h5, 'h33); w('h5, 'hF0); w('h6, 'h98); idle(3); w('h6, 'hF0);
    w('h3, 'h90); w('h3, 'h00); w('h3, 'hA0);
    req = "R12"; w('h555, 'hAA); w('h555, 'hAA); unlock(); w('h555, 'h42); idle(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule